// File: doc/BRIEF.md
# Double-to-int32 truncating converter with wrap-around

This block turns a 64-bit IEEE-754 binary64 value into a signed 32-bit integer. The fraction is cut off toward zero, and the integer keeps only its low 32 bits, so large values wrap modulo 2^32 instead of saturating. This is the numeric conversion a script engine applies before bitwise operators. Three exception flags come with each result: invalid, inexact and input-denormal. A single exactness flag, Z, is true only when the conversion lost nothing, stayed in range and did not produce a zero from a negative input.

A strobe presents one operand. All outputs are registered and change on the clock edge that samples the strobe. A form select picks where Z is written. In the 64-bit form it goes to a 4-bit NZCV output. In the 32-bit form it goes to separate floating-point status N/Z/C/V outputs. A flush-to-zero input changes how subnormal inputs are reported. There is no handshake: a new operand may be given on every cycle.

Top module: `js_dbl_to_i32`

## Requirements
- R1: Fields are sign = bit 63, biased exponent = bits 62:52 and fraction = bits 51:0. For a normal input, the magnitude is (2^52 + fraction) scaled by 2^(exponent−1075) and truncated toward zero, and the result is that magnitude negated in two's complement when the sign is 1.
- R2: An exponent of 0 gives result 0. With a nonzero fraction and flush-to-zero high, only the denormal flag is raised and Z stays true for a positive input. With a nonzero fraction and flush-to-zero low, inexact is raised and Z is false.
- R3: An exponent of 2047 (infinity or NaN) gives result 0, raises invalid and makes Z false.
- R4: The result is the low 32 bits of the truncated magnitude, sign-applied, even when invalid is raised. A scale shift of 64 or more in either direction gives magnitude 0.
- R5: Invalid is raised when the unbiased exponent exceeds 31, or when the 32-bit magnitude exceeds 0x7FFFFFFF for a positive input or 0x80000000 for a negative input. Invalid and inexact are never raised together.
- R6: Inexact is raised when nonzero bits are discarded by the right shift and invalid is not raised. A right shift of 64 or more always counts as discarding bits.
- R7: Z is false whenever invalid or inexact is raised, and also when the sign is 1 and the result is 0 (including −0.0).
- R8: With the form select high, out_nzcv becomes {N=0, Z, C=0, V=0} (bit 3 N, bit 2 Z, bit 1 C, bit 0 V), and the four status outputs keep their values.
- R9: With the form select low, the status outputs become N=0, Z, C=0 and V=0, and out_nzcv keeps its value.
- R10: All outputs update on the clock edge that samples in_strobe high, and out_valid is high for exactly that following cycle. Without a strobe, result, flags and conditions hold.
- R11: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Operand present this cycle |
| in_bits | input | 64 | binary64 operand |
| in_ftz | input | 1 | Flush-to-zero for subnormal inputs |
| in_form64 | input | 1 | 1: Z to out_nzcv, 0: Z to status outputs |
| out_valid | output | 1 | Result registered on the previous edge |
| out_result | output | 32 | Wrapped signed integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |
| out_nzcv | output | 4 | Condition nibble for the 64-bit form |
| out_st_n | output | 1 | Status N for the 32-bit form |
| out_st_z | output | 1 | Status Z for the 32-bit form |
| out_st_c | output | 1 | Status C for the 32-bit form |
| out_st_v | output | 1 | Status V for the 32-bit form |

## Verification
The hardest cases to reach lie at the borders of the exponent range. These are where the right shift first loses every mantissa bit, where a value first stops fitting in 32 bits, and where the lost bits sit just below the leading one. The bench sweeps all 2048 exponents with both signs and several fraction patterns: zero, the lowest bit, the top bit, all ones, and a scrambled value. Flush-to-zero and the form select alternate throughout the sweep. Expected values come from a bit-serial shift model, so the discarded-bit and wrap behaviour is found by a method separate from the design's. Directed operands then cover the named corners: ±0, the extreme subnormals, ±infinity, a NaN, the int32 limits, 2^31, 2^32+5, 1.5, −0.5 and 2^80.

// File: rtl/js_dbl_to_i32.sv
module js_dbl_to_i32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_strobe,
  input  logic [63:0] in_bits,
  input  logic        in_ftz,
  input  logic        in_form64,
  output logic        out_valid,
  output logic [31:0] out_result,
  output logic        out_invalid,
  output logic        out_inexact,
  output logic        out_denorm,
  output logic [3:0]  out_nzcv,
  output logic        out_st_n,
  output logic        out_st_z,
  output logic        out_st_c,
  output logic        out_st_v
);
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int SH_W    = 13;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic signed [SH_W-1:0] SH_OFS = 13'sd1075;
  localparam logic [EXP_W-1:0] EXP_TOP = 11'd1054;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   mnt;
  logic signed [SH_W-1:0] sh, nsh;
  logic        far_l, far_r;
  logic [5:0]  lamt, ramt;
  logic [63:0] mag64;
  logic [31:0] mag32, lim, nres;
  logic        lost, ovf;

  assign sgn  = in_bits[63];
  assign ex   = in_bits[62:52];
  assign frac = in_bits[51:0];
  assign mnt  = {1'b1, frac};
  assign sh   = $signed({2'b00, ex}) - SH_OFS;
  assign nsh  = -sh;
  assign far_l = sh >= 13'sd64;
  assign far_r = sh <= -13'sd64;
  assign lamt  = sh[5:0];
  assign ramt  = nsh[5:0];

  always_comb begin
    if (far_l || far_r)
      mag64 = '0;
    else if (!sh[SH_W-1])
      mag64 = {11'b0, mnt} << lamt;
    else
      mag64 = {11'b0, mnt} >> ramt;
  end

  assign lost  = sh[SH_W-1] && (far_r || |(mnt & ((53'h1 << ramt) - 53'h1)));
  assign mag32 = mag64[31:0];
  assign lim   = sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
  assign ovf   = (ex > EXP_TOP) || (mag32 > lim);
  assign nres  = sgn ? (~mag32 + 32'd1) : mag32;

  logic [31:0] c_res;
  logic        c_inv, c_inx, c_den, c_z;

  always_comb begin
    c_res = '0;
    c_inv = 1'b0;
    c_inx = 1'b0;
    c_den = 1'b0;
    c_z   = 1'b1;
    if (ex == '0) begin
      if (frac != '0) begin
        if (in_ftz) c_den = 1'b1;
        else begin
          c_inx = 1'b1;
          c_z   = 1'b0;
        end
      end
    end else if (ex == EXP_MAX) begin
      c_inv = 1'b1;
      c_z   = 1'b0;
    end else begin
      c_res = nres;
      if (ovf) begin
        c_inv = 1'b1;
        c_z   = 1'b0;
      end else if (lost) begin
        c_inx = 1'b1;
        c_z   = 1'b0;
      end
    end
    if (sgn && c_res == '0) c_z = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
      out_nzcv    <= '0;
      out_st_n    <= 1'b0;
      out_st_z    <= 1'b0;
      out_st_c    <= 1'b0;
      out_st_v    <= 1'b0;
    end else begin
      out_valid <= in_strobe;
      if (in_strobe) begin
        out_result  <= c_res;
        out_invalid <= c_inv;
        out_inexact <= c_inx;
        out_denorm  <= c_den;
        if (in_form64) begin
          out_nzcv <= {1'b0, c_z, 2'b00};
        end else begin
          out_st_n <= 1'b0;
          out_st_z <= c_z;
          out_st_c <= 1'b0;
          out_st_v <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/js_dbl_to_i32_chk.sv
module js_dbl_to_i32_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_strobe,
  input logic [63:0] in_bits,
  input logic        in_ftz,
  input logic        in_form64,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact,
  input logic        out_denorm,
  input logic [3:0]  out_nzcv,
  input logic        out_st_z
);
  assert_inv_excl_inx_R5: assert property (@(posedge clk) disable iff (rst)
    !(out_invalid && out_inexact));

  assert_special_inv_R3: assert property (@(posedge clk) disable iff (rst)
    (in_strobe && in_bits[62:52] == 11'h7FF) |=> (out_invalid && out_result == 32'd0));

  assert_ftz_denorm_R2: assert property (@(posedge clk) disable iff (rst)
    (in_strobe && in_bits[62:52] == 11'h000 && in_bits[51:0] != 52'd0 && in_ftz)
      |=> (out_denorm && !out_inexact && out_result == 32'd0));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_strobe |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_strobe |=> ($stable(out_result) && $stable(out_invalid) && $stable(out_inexact) && !out_valid));

  assert_st_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_strobe && in_form64) |=> $stable(out_st_z));

  assert_nzcv_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (in_strobe && !in_form64) |=> $stable(out_nzcv));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (out_result == 32'd0 && !out_valid && out_nzcv == 4'd0 && !out_st_z));
endmodule

bind js_dbl_to_i32 js_dbl_to_i32_chk u_chk (
  .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_bits(in_bits),
  .in_ftz(in_ftz), .in_form64(in_form64), .out_valid(out_valid),
  .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact),
  .out_denorm(out_denorm), .out_nzcv(out_nzcv), .out_st_z(out_st_z)
);

// File: tb/js_dbl_to_i32_tb.sv
module js_dbl_to_i32_tb;
  logic clk = 1'b0;
  logic rst, in_strobe, in_ftz, in_form64;
  logic [63:0] in_bits;
  logic out_valid, out_invalid, out_inexact, out_denorm;
  logic [31:0] out_result;
  logic [3:0] out_nzcv;
  logic out_st_n, out_st_z, out_st_c, out_st_v;

  int errors = 0;
  int checks = 0;
  logic [3:0] e_nzcv;
  logic [3:0] e_st;

  always #10 clk = ~clk;

  js_dbl_to_i32 u_dut (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_bits(in_bits),
    .in_ftz(in_ftz), .in_form64(in_form64), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact),
    .out_denorm(out_denorm), .out_nzcv(out_nzcv), .out_st_n(out_st_n),
    .out_st_z(out_st_z), .out_st_c(out_st_c), .out_st_v(out_st_v)
  );

  task automatic expect1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] v, input logic ftz,
                       output logic [31:0] r, output logic inv, output logic inx,
                       output logic den, output logic z);
    logic s;
    int e, sh;
    logic [63:0] m;
    logic lostb;
    s = v[63];
    e = int'(v[62:52]);
    r = 0; inv = 0; inx = 0; den = 0; z = 1;
    if (e == 0) begin
      if (v[51:0] != 0) begin
        if (ftz) den = 1;
        else begin inx = 1; z = 0; end
      end
    end else if (e == 2047) begin
      inv = 1; z = 0;
    end else begin
      m = {11'b0, 1'b1, v[51:0]};
      sh = e - 1075;
      lostb = 0;
      if (sh >= 0) begin
        for (int i = 0; i < sh && i < 70; i++) m = m << 1;
      end else begin
        for (int i = 0; i < -sh && i < 70; i++) begin
          lostb = lostb | m[0];
          m = m >> 1;
        end
      end
      if ((e - 1023) > 31 || (!s && m[31:0] > 32'h7FFFFFFF) || (s && m[31:0] > 32'h80000000)) begin
        inv = 1; z = 0;
      end else if (lostb) begin
        inx = 1; z = 0;
      end
      r = s ? (32'd0 - m[31:0]) : m[31:0];
    end
    if (s && r == 0) z = 0;
  endtask

  task automatic run1(input logic [63:0] v, input logic ftz, input logic f64);
    logic [31:0] r;
    logic inv, inx, den, z;
    model(v, ftz, r, inv, inx, den, z);
    in_bits = v; in_ftz = ftz; in_form64 = f64; in_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_strobe = 1'b0;
    if (f64) e_nzcv = {1'b0, z, 2'b00};
    else e_st = {1'b0, z, 2'b00};
    expect1("R1,R4 result", out_result, r);
    expect1("R3,R5 invalid", {31'd0, out_invalid}, {31'd0, inv});
    expect1("R2,R6 inexact", {31'd0, out_inexact}, {31'd0, inx});
    expect1("R2 denorm", {31'd0, out_denorm}, {31'd0, den});
    expect1("R7,R8,R9 nzcv", {28'd0, out_nzcv}, {28'd0, e_nzcv});
    expect1("R7,R8,R9 status", {28'd0, out_st_n, out_st_z, out_st_c, out_st_v}, {28'd0, e_st});
    expect1("R10 valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] hold_r;
    logic [51:0] fr [5];
    e_nzcv = 4'd0; e_st = 4'd0;
    rst = 1'b1; in_strobe = 1'b0; in_bits = '0; in_ftz = 1'b0; in_form64 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect1("R11 reset result", out_result, 32'd0);
    expect1("R11 reset flags", {28'd0, out_valid, out_invalid, out_inexact, out_denorm}, 32'd0);
    expect1("R11 reset cond", {24'd0, out_nzcv, out_st_n, out_st_z, out_st_c, out_st_v}, 32'd0);
    rst = 1'b0;

    run1(64'h0000000000000000, 0, 1);
    run1(64'h8000000000000000, 0, 0);
    run1(64'h0000000000000001, 1, 1);
    run1(64'h0000000000000001, 0, 0);
    run1(64'h000FFFFFFFFFFFFF, 1, 0);
    run1(64'h000FFFFFFFFFFFFF, 0, 1);
    run1(64'h800FFFFFFFFFFFFF, 1, 1);
    run1(64'h7FF0000000000000, 0, 1);
    run1(64'hFFF0000000000000, 0, 0);
    run1(64'h7FF8000000000001, 0, 1);
    run1(64'h41DFFFFFFFC00000, 0, 0);
    run1(64'hC1E0000000000000, 0, 1);
    run1(64'h41E0000000000000, 0, 0);
    run1(64'h41F0000000500000, 0, 1);
    run1(64'h3FF8000000000000, 0, 0);
    run1(64'hBFE0000000000000, 0, 1);
    run1(64'h44F0000000000000, 0, 0);

    hold_r = out_result;
    in_bits = 64'h4000000000000000;
    @(posedge clk);
    @(negedge clk);
    expect1("R10 hold result", out_result, hold_r);
    expect1("R10 no strobe valid", {31'd0, out_valid}, 32'd0);

    fr[0] = 52'd0;
    fr[1] = 52'd1;
    fr[2] = 52'h8000000000000;
    fr[3] = 52'hFFFFFFFFFFFFF;
    for (int e = 0; e < 2048; e++) begin
      fr[4] = 52'(64'(e) * 64'h9E3779B97F4A7C15);
      for (int k = 0; k < 5; k++) begin
        for (int s = 0; s < 2; s++) begin
          run1({s[0], e[10:0], fr[k]}, e[0] ^ k[0], k[0] ^ s[0]);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule